// File: doc/BRIEF.md
# Multicycle Core Main Controller

This block is the sequencing controller for a small multicycle RV32 core that runs register-register ALU instructions, word loads, word stores and branch-if-equal. It is a Moore state machine. It reads the 7-bit opcode field of the instruction register and drives every select and write strobe of a shared datapath. That datapath has one memory for instructions and data, one ALU, and holding registers for the instruction, the operands, the ALU result and the loaded data. Each state takes one clock cycle. In any one cycle the datapath does at most one memory access, one ALU operation, or one register-file access.

The first two states are common to all instructions. Fetch reads the instruction and advances the PC by four. Decode reads both source registers and, whatever the opcode, uses the idle ALU to form PC plus immediate as a candidate branch target. From there the path depends on the instruction class. A branch ends in execute, which takes 3 cycles. ALU instructions and stores end in the memory state, which takes 4 cycles. A load adds a writeback state, for 5 cycles. An unrecognised opcode goes back to fetch directly after decode.

The instruction class is captured on the edge that leaves decode. The rest of the instruction runs on that captured class. All control outputs come straight from flops and always match the state shown on `state_o`.

Top module: `mc_main_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the machine in the fetch state on the next clock edge, even in the middle of an instruction. While reset is held and after it is released, the outputs show the fetch controls. State codes on `state_o` are: fetch=0, decode=1, execute=2, memory=3, writeback=4.
- R2: In fetch, the outputs are as follows:
  - `mem_addr_sel`=0 (PC), `mem_rd`=1, `ir_load`=1, `pc_we`=1, `pc_src_sel`=0 (ALU output).
  - `alu_a_sel`=0 (PC), `alu_b_sel`=01 (constant 4), `alu_op`=00 (add).
  - All other strobes are 0.
  - The next state is always decode.
- R3: In decode, the outputs form PC plus immediate: `alu_a_sel`=0, `alu_b_sel`=10 (immediate), `alu_op`=00. No memory, register-file, IR or PC write or read strobe is active.
- R4: Opcode 1100011 (branch-if-equal) runs fetch, decode, execute, then returns to fetch, for 3 cycles. Its execute state has these outputs:
  - `alu_a_sel`=1 (register A), `alu_b_sel`=00 (register B), `alu_op`=01 (subtract/compare).
  - `pc_we_cond`=1, `pc_src_sel`=1 (ALU result register), `pc_we`=0.
- R5: Opcode 0110011 (register ALU) takes 4 cycles. Its execute state has `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10 (function-field decode). Its memory state has `rf_we`=1, `rf_wdata_sel`=0 (ALU result register) and no memory strobe.
- R6: Opcode 0100011 (store) takes 4 cycles. Its execute state has `alu_a_sel`=1, `alu_b_sel`=10 and `alu_op`=00. Its memory state has `mem_addr_sel`=1 (ALU result register) and `mem_wr`=1, with `mem_rd`=0 and `rf_we`=0.
- R7: Opcode 0000011 (load) takes 5 cycles.
  - Execute has the same address-add controls as a store.
  - The memory state has `mem_addr_sel`=1 and `mem_rd`=1.
  - The writeback state has `rf_we`=1 and `rf_wdata_sel`=1 (loaded data).
- R8: Any other opcode returns to fetch directly after decode, for 2 cycles. No write strobe is raised.
- R9: The class is taken from the opcode only on the edge that leaves decode. Changing `opcode_i` later in the instruction does not change the rest of that instruction.
- R10: In no cycle are `mem_rd` and `mem_wr` both high. In no cycle is `rf_we` high together with a memory strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 7 | Opcode field of the instruction register |
| state_o | output | 3 | Current state code |
| mem_addr_sel | output | 1 | Memory address source: 0 PC, 1 ALU result register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_load | output | 1 | Instruction register load |
| rf_we | output | 1 | Register file write enable |
| rf_wdata_sel | output | 1 | Register write data: 0 ALU result register, 1 loaded data |
| alu_a_sel | output | 1 | ALU input A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU input B: 00 register B, 01 constant 4, 10 immediate |
| alu_op | output | 2 | 00 add, 01 subtract/compare, 10 function-field decode |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_cond | output | 1 | PC write qualified by operand equality |
| pc_src_sel | output | 1 | PC source: 0 ALU output, 1 ALU result register |

## Verification
The bench walks each opcode class state by state, compares every control field, and checks the length of each instruction.

- **Length errors.** A wrong cycle count for any class shows up as a mismatch, for example a branch that lingers into the memory state, or a load that ends before writeback.
- **Wrong strobes.** A design that swapped the load and store strobes, or that wrote the register file from the wrong source, fails the field comparison in the memory or writeback state.
- **Unknown opcodes.** A design that let an unknown opcode into execute would raise write strobes where none are allowed.
- **Late opcode changes.** The opcode is switched in the middle of a load. A design that re-decoded it instead of using the captured class would go down the branch or store path.
- **Reset during an instruction.** Reset is asserted mid-instruction to show that it forces fetch regardless of the current state.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int STATE_W = 3;
  localparam int CLASS_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEM    = 3'd3,
    ST_WB     = 3'd4
  } state_e;

  typedef enum logic [CLASS_W-1:0] {
    CL_ALU = 3'd0,
    CL_LD  = 3'd1,
    CL_ST  = 3'd2,
    CL_BR  = 3'd3,
    CL_BAD = 3'd4
  } iclass_e;

  localparam logic [1:0] BSEL_REG = 2'b00;
  localparam logic [1:0] BSEL_FOUR = 2'b01;
  localparam logic [1:0] BSEL_IMM = 2'b10;

  localparam logic [1:0] AOP_ADD = 2'b00;
  localparam logic [1:0] AOP_SUB = 2'b01;
  localparam logic [1:0] AOP_FUNC = 2'b10;

  typedef struct packed {
    logic       addr_sel;
    logic       mrd;
    logic       mwr;
    logic       irld;
    logic       rfwe;
    logic       wsel;
    logic       asel;
    logic [1:0] bsel;
    logic [1:0] aop;
    logic       pcwe;
    logic       pcwc;
    logic       psel;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '0;

endpackage

// File: rtl/mcc_opdecode.sv
module mcc_opdecode
  import mcc_pkg::*;
#(
  parameter int         OPC_W  = 7,
  parameter logic [6:0] OPC_ALU = 7'b0110011,
  parameter logic [6:0] OPC_LD  = 7'b0000011,
  parameter logic [6:0] OPC_ST  = 7'b0100011,
  parameter logic [6:0] OPC_BR  = 7'b1100011
) (
  input  logic [OPC_W-1:0] opcode,
  output iclass_e          iclass
);

  always_comb begin
    if (opcode == OPC_W'(OPC_ALU))     iclass = CL_ALU;
    else if (opcode == OPC_W'(OPC_LD)) iclass = CL_LD;
    else if (opcode == OPC_W'(OPC_ST)) iclass = CL_ST;
    else if (opcode == OPC_W'(OPC_BR)) iclass = CL_BR;
    else                               iclass = CL_BAD;
  end

endmodule

// File: rtl/mcc_sequencer.sv
module mcc_sequencer
  import mcc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  iclass_e dec_class,
  output state_e  state_q,
  output state_e  state_d,
  output iclass_e class_q,
  output iclass_e class_d
);

  always_comb begin
    class_d = (state_q == ST_DECODE) ? dec_class : class_q;
  end

  always_comb begin
    state_d = ST_FETCH;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = (dec_class == CL_BAD) ? ST_FETCH : ST_EXEC;
      ST_EXEC:   state_d = (class_q == CL_BR) ? ST_FETCH : ST_MEM;
      ST_MEM:    state_d = (class_q == CL_LD) ? ST_WB : ST_FETCH;
      ST_WB:     state_d = ST_FETCH;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      class_q <= CL_BAD;
    end else begin
      state_q <= state_d;
      class_q <= class_d;
    end
  end

  // Sequencing checks
  assert_reset_to_fetch_R1: assert property (@(posedge clk)
    $past(rst) |-> state_q == ST_FETCH);

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_FETCH |=> state_q == ST_DECODE);

  assert_branch_ends_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXEC && class_q == CL_BR) |=> state_q == ST_FETCH);

  assert_load_writeback_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MEM && class_q == CL_LD) |=> state_q == ST_WB);

  assert_bad_opcode_exit_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DECODE && dec_class == CL_BAD) |=> state_q == ST_FETCH);

  assert_class_held_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXEC || state_q == ST_MEM) |=> $stable(class_q));

endmodule

// File: rtl/mcc_outdec.sv
module mcc_outdec
  import mcc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  state_e  state_d,
  input  iclass_e class_d,
  input  state_e  state_q,
  output ctrl_t   ctrl_q
);

  function automatic ctrl_t ctrl_for(state_e st, iclass_e cl);
    ctrl_t c;
    c = CTRL_IDLE;
    unique case (st)
      ST_FETCH: begin
        c.mrd  = 1'b1;
        c.irld = 1'b1;
        c.bsel = BSEL_FOUR;
        c.aop  = AOP_ADD;
        c.pcwe = 1'b1;
      end
      ST_DECODE: begin
        c.bsel = BSEL_IMM;
        c.aop  = AOP_ADD;
      end
      ST_EXEC: begin
        c.asel = 1'b1;
        unique case (cl)
          CL_ALU: begin
            c.bsel = BSEL_REG;
            c.aop  = AOP_FUNC;
          end
          CL_BR: begin
            c.bsel = BSEL_REG;
            c.aop  = AOP_SUB;
            c.pcwc = 1'b1;
            c.psel = 1'b1;
          end
          CL_LD, CL_ST: begin
            c.bsel = BSEL_IMM;
            c.aop  = AOP_ADD;
          end
          default: c.asel = 1'b0;
        endcase
      end
      ST_MEM: begin
        unique case (cl)
          CL_LD: begin
            c.addr_sel = 1'b1;
            c.mrd      = 1'b1;
          end
          CL_ST: begin
            c.addr_sel = 1'b1;
            c.mwr      = 1'b1;
          end
          CL_ALU: begin
            c.rfwe = 1'b1;
            c.wsel = 1'b0;
          end
          default: c = CTRL_IDLE;
        endcase
      end
      ST_WB: begin
        c.rfwe = 1'b1;
        c.wsel = 1'b1;
      end
      default: c = CTRL_IDLE;
    endcase
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= ctrl_for(ST_FETCH, CL_BAD);
    else     ctrl_q <= ctrl_for(state_d, class_d);
  end

  // Output checks against the sequencer state
  assert_mem_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_q.mrd && ctrl_q.mwr));

  assert_rf_mem_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_q.rfwe && (ctrl_q.mrd || ctrl_q.mwr)));

  assert_fetch_strobes_R2: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_FETCH |-> (ctrl_q.irld && ctrl_q.pcwe && ctrl_q.mrd));

  assert_decode_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_DECODE |-> !(ctrl_q.mrd || ctrl_q.mwr || ctrl_q.rfwe ||
                               ctrl_q.irld || ctrl_q.pcwe || ctrl_q.pcwc));

  assert_cond_pc_exec_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl_q.pcwc |-> state_q == ST_EXEC);

endmodule

// File: rtl/mc_main_ctrl.sv
module mc_main_ctrl
  import mcc_pkg::*;
#(
  parameter int         OPC_W   = 7,
  parameter logic [6:0] OPC_ALU = 7'b0110011,
  parameter logic [6:0] OPC_LD  = 7'b0000011,
  parameter logic [6:0] OPC_ST  = 7'b0100011,
  parameter logic [6:0] OPC_BR  = 7'b1100011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode_i,
  output logic [2:0]       state_o,
  output logic             mem_addr_sel,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_load,
  output logic             rf_we,
  output logic             rf_wdata_sel,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_op,
  output logic             pc_we,
  output logic             pc_we_cond,
  output logic             pc_src_sel
);

  iclass_e dec_class;
  iclass_e class_q;
  iclass_e class_d;
  state_e  state_q;
  state_e  state_d;
  ctrl_t   ctrl_q;

  mcc_opdecode #(
    .OPC_W  (OPC_W),
    .OPC_ALU(OPC_ALU),
    .OPC_LD (OPC_LD),
    .OPC_ST (OPC_ST),
    .OPC_BR (OPC_BR)
  ) u_dec (
    .opcode(opcode_i),
    .iclass(dec_class)
  );

  mcc_sequencer u_seq (
    .clk      (clk),
    .rst      (rst),
    .dec_class(dec_class),
    .state_q  (state_q),
    .state_d  (state_d),
    .class_q  (class_q),
    .class_d  (class_d)
  );

  mcc_outdec u_out (
    .clk    (clk),
    .rst    (rst),
    .state_d(state_d),
    .class_d(class_d),
    .state_q(state_q),
    .ctrl_q (ctrl_q)
  );

  assign state_o      = state_q;
  assign mem_addr_sel = ctrl_q.addr_sel;
  assign mem_rd       = ctrl_q.mrd;
  assign mem_wr       = ctrl_q.mwr;
  assign ir_load      = ctrl_q.irld;
  assign rf_we        = ctrl_q.rfwe;
  assign rf_wdata_sel = ctrl_q.wsel;
  assign alu_a_sel    = ctrl_q.asel;
  assign alu_b_sel    = ctrl_q.bsel;
  assign alu_op       = ctrl_q.aop;
  assign pc_we        = ctrl_q.pcwe;
  assign pc_we_cond   = ctrl_q.pcwc;
  assign pc_src_sel   = ctrl_q.psel;

endmodule

// File: tb/mc_main_ctrl_test.sv
module mc_main_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] opcode_i = 7'd0;
  logic [2:0] state_o;
  logic       mem_addr_sel, mem_rd, mem_wr, ir_load, rf_we, rf_wdata_sel;
  logic       alu_a_sel, pc_we, pc_we_cond, pc_src_sel;
  logic [1:0] alu_b_sel, alu_op;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mc_main_ctrl uut (
    .clk(clk), .rst(rst), .opcode_i(opcode_i), .state_o(state_o),
    .mem_addr_sel(mem_addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .ir_load(ir_load), .rf_we(rf_we), .rf_wdata_sel(rf_wdata_sel),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .pc_we(pc_we), .pc_we_cond(pc_we_cond), .pc_src_sel(pc_src_sel)
  );

  // {opcode, expected cycle count}
  localparam logic [10:0] VEC [10] = '{
    {7'b0110011, 4'd4}, {7'b0000011, 4'd5}, {7'b0100011, 4'd4},
    {7'b1100011, 4'd3}, {7'b0010011, 4'd2}, {7'b1111111, 4'd2},
    {7'b1100011, 4'd3}, {7'b0000011, 4'd5}, {7'b0000000, 4'd2},
    {7'b0110011, 4'd4}
  };

  // class: 0 alu, 1 load, 2 store, 3 branch, 4 other
  function automatic int cls_of(logic [6:0] op);
    case (op)
      7'b0110011: return 0;
      7'b0000011: return 1;
      7'b0100011: return 2;
      7'b1100011: return 3;
      default:    return 4;
    endcase
  endfunction

  // {addr_sel, rd, wr, irld, rfwe, wsel, asel, bsel[2], aop[2], pcwe, pcwc, psel}
  function automatic logic [13:0] exp_ctrl(int st, int cl);
    case (st)
      0: return 14'b0_1_0_1_0_0_0_01_00_1_0_0;
      1: return 14'b0_0_0_0_0_0_0_10_00_0_0_0;
      2: case (cl)
           0: return 14'b0_0_0_0_0_0_1_00_10_0_0_0;
           3: return 14'b0_0_0_0_0_0_1_00_01_0_1_1;
           default: return 14'b0_0_0_0_0_0_1_10_00_0_0_0;
         endcase
      3: case (cl)
           0: return 14'b0_0_0_0_1_0_0_00_00_0_0_0;
           1: return 14'b1_1_0_0_0_0_0_00_00_0_0_0;
           default: return 14'b1_0_1_0_0_0_0_00_00_0_0_0;
         endcase
      default: return 14'b0_0_0_0_1_1_0_00_00_0_0_0;
    endcase
  endfunction

  function automatic int exp_next(int st, int cl);
    case (st)
      0: return 1;
      1: return (cl == 4) ? 0 : 2;
      2: return (cl == 3) ? 0 : 3;
      3: return (cl == 1) ? 4 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(int st, int cl);
    if (st == 0) return "R2";
    if (st == 1) return "R3";
    case (cl)
      0: return "R5";
      1: return "R7";
      2: return "R6";
      3: return "R4";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [13:0] act_ctrl();
    return {mem_addr_sel, mem_rd, mem_wr, ir_load, rf_we, rf_wdata_sel,
            alu_a_sel, alu_b_sel, alu_op, pc_we, pc_we_cond, pc_src_sel};
  endfunction

  task automatic check_now(string req, int st, int cl);
    checks++;
    if (state_o !== 3'(st) || act_ctrl() !== exp_ctrl(st, cl)) begin
      errors++;
      $display("FAIL %s: state=%0d ctrl=%b expected state=%0d ctrl=%b",
               req, state_o, act_ctrl(), st, exp_ctrl(st, cl));
    end
  endtask

  // Walk one instruction from fetch; swap_op replaces the opcode once execute is reached
  task automatic run_instr(logic [6:0] op, int exp_len, bit swap, logic [6:0] swap_op,
                           string len_req);
    int st = 0;
    int cl = cls_of(op);
    int n = 0;
    opcode_i = op;
    for (int k = 0; k < 8; k++) begin
      if (swap && st == 2) opcode_i = swap_op;
      check_now(req_of(st, cl), st, cl);
      st = exp_next(st, cl);
      n++;
      @(negedge clk);
      if (st == 0) break;
    end
    checks++;
    if (n != exp_len || state_o !== 3'd0) begin
      errors++;
      $display("FAIL %s: length=%0d end_state=%0d expected length=%0d end_state=0",
               len_req, n, state_o, exp_len);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_now("R1", 0, 4);               // reset held: fetch controls
    rst = 1'b0;

    foreach (VEC[i]) begin
      int c = cls_of(VEC[i][10:4]);
      string r = (c == 0) ? "R5" : (c == 1) ? "R7" : (c == 2) ? "R6" :
                 (c == 3) ? "R4" : "R8";
      run_instr(VEC[i][10:4], int'(VEC[i][3:0]), 1'b0, 7'd0, r);
    end

    // R9: load whose opcode turns into a branch after decode still runs 5 cycles
    run_instr(7'b0000011, 5, 1'b1, 7'b1100011, "R9");
    // R9: branch whose opcode turns into a store after decode still ends after execute
    run_instr(7'b1100011, 3, 1'b1, 7'b0100011, "R9");

    // R1: reset asserted during execute of an ALU instruction
    opcode_i = 7'b0110011;
    repeat (2) @(negedge clk);
    check_now("R1", 2, 0);
    rst = 1'b1;
    @(negedge clk);
    check_now("R1", 0, 4);
    rst = 1'b0;
    @(negedge clk);
    check_now("R1", 1, 0);
    @(negedge clk);
    check_now("R1", 2, 0);
    repeat (2) @(negedge clk);
    check_now("R1", 0, 4);

    // R10: store followed by load; strobes checked every cycle by the walk
    run_instr(7'b0100011, 4, 1'b0, 7'd0, "R10");
    run_instr(7'b0000011, 5, 1'b0, 7'd0, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule